// File: doc/BRIEF.md
# Overcurrent Pulse-Skip and Latch-Off Controller

This block is the digital fault controller of a synchronous buck regulator. It receives a comparator flag that says the sensed inductor current is above the limit. It also receives a strobe that marks each switching period. From these it decides whether an overload is a short event or a sustained fault. While the flag is high, the high-side drive request is blocked, so the converter skips pulses.

The first rise of the flag opens a monitoring sequence made of two back-to-back windows. Each window lasts a parameterised number of switching ticks, eight by default. A flag seen during the first window only causes pulse skipping. A flag seen at any time during the second window latches a fault. The fault turns both drive requests off and pulls power-good low. If the second window closes clean, the monitor returns to idle, 16 ticks after the first trip.

A separate under-voltage comparator flag latches the same fault at once, with no window. This flag is ignored while an output-voltage code change is in progress. The latch is released only by taking the enable input low or by the power-on reset.

Top module: `oc_shutdown_ctrl`

## Requirements
- R1: While `por_n` is low, and on the first cycle after it is released with `en_i` low, `fault_o`, `hs_drv_o`, `ls_drv_o` and `pgood_o` are all 0.
- R2: `hs_drv_o` equals `hs_req_i` AND `en_i` AND NOT `oc_i` AND NOT fault, in the same cycle. Over-current therefore blocks high-side pulses combinationally.
- R3: A 0-to-1 change of `oc_i`, sampled with the monitor idle, opens the first window. While the first window is open, `oc_i` held high does not set the fault, however long it stays high.
- R4: The first window closes on the clock edge that samples its eighth `tick_i` pulse counted after the trip cycle. If `oc_i` is sampled high in any cycle from the next one up to and including the cycle of the sixteenth tick, `fault_o` is 1 from the following cycle.
- R5: If `oc_i` stays low through the whole second window, the monitor is idle after the sixteenth tick. A later rise of `oc_i` then opens a fresh first window and does not latch.
- R6: While the fault is latched, `hs_drv_o`, `ls_drv_o` and `pgood_o` are 0. The window counters do not advance.
- R7: A latched fault stays set whatever `oc_i`, `uv_i` or `tick_i` do. It clears only after a cycle with `en_i` low, or on `por_n` low.
- R8: `uv_i` sampled high with `en_i` high and `vid_busy_i` low sets `fault_o` on the next cycle, with no tick needed.
- R9: `uv_i` has no effect while `vid_busy_i` is high.
- R10: While `en_i` is low, all outputs are 0 and the monitor is returned to idle. An `oc_i` already high when enable rises counts as a first trip.
- R11: Window counters advance only in cycles where `tick_i` is high. Any number of cycles without a tick leaves the monitor in the same window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| en_i | input | 1 | Converter enable; low also clears a latched fault |
| tick_i | input | 1 | One-cycle strobe per switching period |
| oc_i | input | 1 | Over-current comparator flag, synchronous |
| uv_i | input | 1 | Under-voltage comparator flag, synchronous |
| vid_busy_i | input | 1 | High while an output-voltage code change is in progress |
| hs_req_i | input | 1 | High-side drive request from the modulator |
| ls_req_i | input | 1 | Low-side drive request from the modulator |
| pgood_i | input | 1 | Raw power-good from the voltage monitor |
| hs_drv_o | output | 1 | Gated high-side drive request |
| ls_drv_o | output | 1 | Gated low-side drive request |
| pgood_o | output | 1 | Power-good after fault and enable gating |
| fault_o | output | 1 | Latched shutdown fault |

## Verification
Two events can fall in the same cycle: the over-current flag and the final tick of the second window. In that cycle the latch must win, and the monitor must not slip back to idle. The bench provokes this by keeping the flag low until the sixteenth tick and raising it in exactly that cycle. A behavioural model then expects the fault on the next cycle. A second overlap comes from the under-voltage flag arriving while a code change is in progress. The bench asserts both together and checks that the fault stays clear until the busy indication drops.

// File: rtl/ocg_pkg.sv
package ocg_pkg;

    typedef enum logic [1:0] {
        MON_IDLE   = 2'd0,
        MON_FIRST  = 2'd1,
        MON_SECOND = 2'd2
    } mon_state_e;

endpackage

// File: rtl/ocg_window.sv
module ocg_window
    import ocg_pkg::*;
#(
    parameter int WIN_TICKS = 8
) (
    input  logic clk,
    input  logic por_n,
    input  logic en_i,
    input  logic tick_i,
    input  logic oc_i,
    input  logic hold_i,
    output logic second_o
);
    localparam int CW = (WIN_TICKS > 1) ? $clog2(WIN_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIN_TICKS - 1);

    typedef struct packed {
        mon_state_e     st;
        logic [CW-1:0]  cnt;
        logic           oc_prev;
    } win_t;

    win_t win_d, win_q;

    always_comb begin
        win_d = win_q;
        win_d.oc_prev = en_i & oc_i;
        if (!en_i) begin
            win_d.st  = MON_IDLE;
            win_d.cnt = '0;
        end else if (!hold_i) begin
            case (win_q.st)
                MON_IDLE: begin
                    if (oc_i && !win_q.oc_prev) begin
                        win_d.st  = MON_FIRST;
                        win_d.cnt = '0;
                    end
                end
                MON_FIRST: begin
                    if (tick_i) begin
                        if (win_q.cnt == LAST) begin
                            win_d.st  = MON_SECOND;
                            win_d.cnt = '0;
                        end else begin
                            win_d.cnt = win_q.cnt + 1'b1;
                        end
                    end
                end
                MON_SECOND: begin
                    if (tick_i) begin
                        if (win_q.cnt == LAST) begin
                            win_d.st  = MON_IDLE;
                            win_d.cnt = '0;
                        end else begin
                            win_d.cnt = win_q.cnt + 1'b1;
                        end
                    end
                end
                default: begin
                    win_d.st  = MON_IDLE;
                    win_d.cnt = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            win_q <= '{st: MON_IDLE, cnt: '0, oc_prev: 1'b0};
        end else begin
            win_q <= win_d;
        end
    end

    assign second_o = (win_q.st == MON_SECOND);

    // Window position is frozen while the fault holds it.
    assert_frozen_on_fault_R6: assert property (@(posedge clk) disable iff (!por_n)
        (hold_i && en_i) |=> ($stable(win_q.cnt) && $stable(win_q.st)));

    // No tick, no progress inside an open window.
    assert_tick_only_advance_R11: assert property (@(posedge clk) disable iff (!por_n)
        (en_i && !tick_i && !hold_i && win_q.st != MON_IDLE) |=> $stable(win_q.cnt) && $stable(win_q.st));

    // Disable returns the monitor to idle.
    assert_idle_when_disabled_R10: assert property (@(posedge clk) disable iff (!por_n)
        !en_i |=> (win_q.st == MON_IDLE));

endmodule

// File: rtl/ocg_latch.sv
module ocg_latch (
    input  logic clk,
    input  logic por_n,
    input  logic en_i,
    input  logic oc_i,
    input  logic second_i,
    input  logic uv_i,
    input  logic vid_busy_i,
    output logic set_o,
    output logic fault_o
);
    typedef struct packed {
        logic fault;
    } lat_t;

    lat_t lat_d, lat_q;
    logic trip_oc, trip_uv;

    always_comb begin
        trip_oc = second_i & oc_i;
        trip_uv = uv_i & ~vid_busy_i;
        set_o   = en_i & (trip_oc | trip_uv);
        lat_d   = lat_q;
        if (!en_i) begin
            lat_d.fault = 1'b0;
        end else if (set_o) begin
            lat_d.fault = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            lat_q <= '{fault: 1'b0};
        end else begin
            lat_q <= lat_d;
        end
    end

    assign fault_o = lat_q.fault;

    assert_fault_sticky_R7: assert property (@(posedge clk) disable iff (!por_n)
        (fault_o && en_i) |=> fault_o);

    assert_uv_immediate_R8: assert property (@(posedge clk) disable iff (!por_n)
        (en_i && uv_i && !vid_busy_i) |=> fault_o);

    assert_second_window_trip_R4: assert property (@(posedge clk) disable iff (!por_n)
        (en_i && second_i && oc_i) |=> fault_o);

    assert_enable_clears_R10: assert property (@(posedge clk) disable iff (!por_n)
        !en_i |=> !fault_o);

endmodule

// File: rtl/ocg_gate.sv
module ocg_gate (
    input  logic en_i,
    input  logic fault_i,
    input  logic oc_i,
    input  logic hs_req_i,
    input  logic ls_req_i,
    input  logic pgood_i,
    output logic hs_drv_o,
    output logic ls_drv_o,
    output logic pgood_o
);
    logic run;

    always_comb begin
        run      = en_i & ~fault_i;
        hs_drv_o = run & hs_req_i & ~oc_i;
        ls_drv_o = run & ls_req_i;
        pgood_o  = run & pgood_i;
    end

endmodule

// File: rtl/oc_shutdown_ctrl.sv
module oc_shutdown_ctrl #(
    parameter int WIN_TICKS = 8
) (
    input  logic clk,
    input  logic por_n,
    input  logic en_i,
    input  logic tick_i,
    input  logic oc_i,
    input  logic uv_i,
    input  logic vid_busy_i,
    input  logic hs_req_i,
    input  logic ls_req_i,
    input  logic pgood_i,
    output logic hs_drv_o,
    output logic ls_drv_o,
    output logic pgood_o,
    output logic fault_o
);
    logic second_w;
    logic set_w;
    logic fault_w;
    logic hold_w;

    assign hold_w = fault_w | set_w;

    ocg_window #(.WIN_TICKS(WIN_TICKS)) u_window (
        .clk      (clk),
        .por_n    (por_n),
        .en_i     (en_i),
        .tick_i   (tick_i),
        .oc_i     (oc_i),
        .hold_i   (hold_w),
        .second_o (second_w)
    );

    ocg_latch u_latch (
        .clk        (clk),
        .por_n      (por_n),
        .en_i       (en_i),
        .oc_i       (oc_i),
        .second_i   (second_w),
        .uv_i       (uv_i),
        .vid_busy_i (vid_busy_i),
        .set_o      (set_w),
        .fault_o    (fault_w)
    );

    ocg_gate u_gate (
        .en_i     (en_i),
        .fault_i  (fault_w),
        .oc_i     (oc_i),
        .hs_req_i (hs_req_i),
        .ls_req_i (ls_req_i),
        .pgood_i  (pgood_i),
        .hs_drv_o (hs_drv_o),
        .ls_drv_o (ls_drv_o),
        .pgood_o  (pgood_o)
    );

    assign fault_o = fault_w;

    // Masked under-voltage alone never creates a fault.
    assert_uv_masked_R9: assert property (@(posedge clk) disable iff (!por_n)
        (!fault_o && uv_i && vid_busy_i && !(second_w && oc_i)) |=> !fault_o);

    assert_drives_off_R6: assert property (@(posedge clk) disable iff (!por_n)
        fault_o |-> (!hs_drv_o && !ls_drv_o && !pgood_o));

endmodule

// File: tb/oc_shutdown_ctrl_tb.sv
`timescale 1ns/100ps
module oc_shutdown_ctrl_tb_top;
    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic en = 1'b0, tick = 1'b0, oc = 1'b0, uv = 1'b0, busy = 1'b0;
    logic hs_req = 1'b0, ls_req = 1'b0, pg_in = 1'b0;
    logic hs_drv, ls_drv, pg_out, fault;

    int total = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    oc_shutdown_ctrl dut_i (
        .clk(clk), .por_n(por_n), .en_i(en), .tick_i(tick), .oc_i(oc),
        .uv_i(uv), .vid_busy_i(busy), .hs_req_i(hs_req), .ls_req_i(ls_req),
        .pgood_i(pg_in), .hs_drv_o(hs_drv), .ls_drv_o(ls_drv),
        .pgood_o(pg_out), .fault_o(fault)
    );

    // Behavioural reference: ticks since the first trip, -1 when idle.
    bit m_fault;
    int m_ticks;
    bit m_ocp;

    always @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            m_fault <= 0; m_ticks <= -1; m_ocp <= 0;
        end else if (!en) begin
            m_fault <= 0; m_ticks <= -1; m_ocp <= 0;
        end else begin
            m_ocp <= oc;
            if (m_fault) begin
                m_fault <= 1;
            end else if ((m_ticks >= 8 && oc) || (uv && !busy)) begin
                m_fault <= 1;
            end else if (m_ticks < 0) begin
                if (oc && !m_ocp) m_ticks <= 0;
            end else if (tick) begin
                m_ticks <= (m_ticks + 1 == 16) ? -1 : m_ticks + 1;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every cycle, away from the rising edge.
    always @(negedge clk) begin
        bit e_hs, e_ls, e_pg;
        e_hs = hs_req && en && !m_fault && !oc;
        e_ls = ls_req && en && !m_fault;
        e_pg = pg_in && en && !m_fault;
        check(hs_drv == e_hs, "R2 hs_drv", hs_drv, e_hs);
        check(ls_drv == e_ls, "R6 ls_drv", ls_drv, e_ls);
        check(pg_out == e_pg, "R6 pgood", pg_out, e_pg);
        check(fault == m_fault, "R4 fault model", fault, m_fault);
    end

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    // n tick pulses, each followed by gap idle cycles
    task automatic ticks(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            tick = 1; step(1); tick = 0; step(gap);
        end
    endtask

    task automatic expect_fault(input bit exp, input string tag);
        @(negedge clk);
        check(fault == exp, tag, fault, exp);
        @(posedge clk); #1;
    endtask

    initial begin
        #1_000_000;
        total++; fails++;
        $display("FAIL watchdog expired (R1 run did not complete)");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        // R1: reset state
        #12;
        check(fault == 0 && pg_out == 0 && hs_drv == 0 && ls_drv == 0, "R1 reset outputs", fault, 0);
        @(posedge clk); #1; por_n = 1;
        step(1);
        check(fault == 0 && pg_out == 0, "R1 after release", fault, 0);

        en = 1; hs_req = 1; ls_req = 1; pg_in = 1;
        step(2);
        check(hs_drv == 1, "R2 hs passes", hs_drv, 1);
        oc = 1; #0.5;
        check(hs_drv == 0, "R2 hs blocked by oc", hs_drv, 0);
        step(1); oc = 0;

        // R5: clean second window -> idle after 16 ticks
        ticks(16, 2);
        expect_fault(0, "R5 clean window no fault");
        oc = 1; step(1);
        // R3: oc held through the fresh first window
        ticks(7, 1);
        tick = 1; step(1); tick = 0;
        expect_fault(0, "R3 first window tolerant");
        // now in second window, oc still high
        step(1);
        expect_fault(1, "R4 second window trip");

        // R6/R7: fault holds regardless of inputs
        oc = 0; uv = 0; ticks(20, 1);
        expect_fault(1, "R7 sticky fault");
        check(hs_drv == 0 && ls_drv == 0 && pg_out == 0, "R6 drives off", hs_drv, 0);

        // R10/R7: enable toggle clears
        en = 0; step(1);
        check(hs_drv == 0 && ls_drv == 0 && pg_out == 0, "R10 disabled outputs", ls_drv, 0);
        en = 1;
        expect_fault(0, "R7 enable toggle clears");

        // R11: no ticks, oc re-asserted, monitor stays in first window
        oc = 1; step(1); oc = 0; step(3); oc = 1;
        step(50);
        expect_fault(0, "R11 no tick no advance");
        oc = 0;
        // collision: oc rises on the 16th tick cycle
        ticks(15, 2);
        tick = 1; oc = 1; step(1); tick = 0;
        expect_fault(1, "R4 trip on final tick");
        oc = 0;

        // R10: oc high at enable counts as trip
        en = 0; step(1); oc = 1; en = 1; step(1); oc = 0;
        ticks(8, 1);
        oc = 1; step(1); oc = 0;
        expect_fault(1, "R10 trip at enable");

        // R9 / R8
        en = 0; step(1); en = 1; step(20);
        busy = 1; uv = 1; step(5);
        expect_fault(0, "R9 uv masked by busy");
        busy = 0; step(1);
        expect_fault(1, "R8 uv immediate");
        uv = 0;

        // R7: power-on reset clears
        por_n = 0; #1;
        check(fault == 0, "R7 por clears", fault, 0);
        step(1); por_n = 1; step(3);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule